// File: doc/BRIEF.md
# Shift and Normalize Unit

This block is the shifting stage of a 16-bit fixed-point datapath. Each accepted operand is placed into a 32-bit field, either in the upper half or in the lower half, and then shifted left or right under control of an operation code. The block can shift logically or arithmetically by a signed count. It can also find the exponent of a value from its redundant sign bits, then shift a value left by that exponent to normalize it or right by it to denormalize it. The result and the exponent sit in registers, so any unit that consumes them can use them on the next clock cycle.

Values wider than one word are handled one word at a time. An OR-merge option combines the newly shifted field with the previous 32-bit result. The stored exponent and the sign of the upper word carry over from one operation to the next. A two-word value can therefore be measured, normalized or denormalized in a short fixed sequence of operations: exponent of the upper word, exponent of the lower word, then a shift of each word with the second one merged.

Top module: `shx_unit`

## Requirements
- R1: While reset is asserted and after it is released, result is 0, exponent is 0 and out_valid is 0 until the first operand is accepted.
- R2: out_valid is high in exactly the cycle after in_valid was high. result and exponent change only in response to an accepted operand (in_valid high).
- R3: op_sel 0 is a logical shift by shift_amt (8-bit two's complement). A positive count shifts left and a negative count shifts right, and vacated bits are filled with 0. With hi_half 1 the operand occupies bits 31:16 and bits 15:0 are 0. With hi_half 0 the operand occupies bits 15:0 and bits 31:16 are 0.
- R4: op_sel 1 is an arithmetic shift by shift_amt. With hi_half 0 the operand is sign-extended into bits 31:16. A right shift fills vacated bits with bit 31 of the placed value.
- R5: A shift count with magnitude 32 or more, including -128, gives all zeros. The one exception is an arithmetic right shift, which gives 32 copies of the sign bit.
- R6: op_sel 4 with hi_half 1 sets the exponent to minus the number of redundant sign bits of the operand, which lies in the range 0 to -15. An operand of all zeros or all ones gives -15. This operation leaves result unchanged.
- R7: op_sel 4 with hi_half 0 works as follows when the stored exponent is -15. It subtracts the number of leading bits of the operand that equal the sign of the last upper word measured, so the exponent can reach -31. When the stored exponent is any other value, this operation leaves the exponent unchanged. Either way, result is unchanged.
- R8: op_sel 2 normalizes. It shifts the placed operand left by the negated stored exponent and leaves the exponent unchanged. The upper half is placed with zero low bits, and the lower half is zero-extended.
- R9: op_sel 3 denormalizes. It shifts by the stored exponent, which moves the value right when the exponent is negative. The upper half is shifted arithmetically and the lower half logically (zero-extended). The exponent is left unchanged.
- R10: When merge_en is 1, the new result is the shifted field ORed with the previous result. When merge_en is 0, the new result is the shifted field alone.
- R11: op_sel values 5, 6 and 7 leave result and exponent unchanged. out_valid still follows R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand and controls are accepted this cycle |
| op_sel | input | 3 | Operation: 0 logical, 1 arithmetic, 2 normalize, 3 denormalize, 4 exponent |
| hi_half | input | 1 | 1 places the operand in bits 31:16, 0 in bits 15:0 |
| merge_en | input | 1 | OR the shifted field into the previous result |
| shift_amt | input | 8 | Signed shift count for op_sel 0 and 1 |
| operand | input | 16 | Input data word |
| out_valid | output | 1 | Result and exponent were updated by the last accepted operand |
| result | output | 32 | Registered shift result |
| exponent | output | 8 | Registered signed exponent |

## Verification
The bench targets the count boundaries: ±31 against ±32, -40, +127 and -128. A barrel that ignores the high count bits would wrap instead of saturating. A barrel that fills an arithmetic right shift with zeros would lose negative values.

The exponent is tested on single bit patterns and on the all-zeros and all-ones extremes. It is also tested through the lower-word extension, once with a stored -15 and once without. An off-by-one in the leading-bit count, or an extension that ignores the stored upper sign, would show up as a wrong exponent.

Full two-word normalize and denormalize sequences, run with merge enabled, expose two kinds of error. One is a lower word that is sign-extended when it should be zero-extended. The other is a merge that overwrites the previous result instead of combining with it. Reserved codes and idle cycles are checked to leave both registers untouched.

// File: rtl/shx_pkg.sv
package shx_pkg;
   typedef enum logic [2:0] {
      OP_LSH    = 3'd0,
      OP_ASH    = 3'd1,
      OP_NORM   = 3'd2,
      OP_DENORM = 3'd3,
      OP_EXP    = 3'd4
   } shx_op_e;
endpackage

// File: rtl/shx_barrel.sv
module shx_barrel #(
   parameter int  W          = 32,
   parameter int  CNT_W      = 8,
   parameter bit  LOG_STAGES = 1'b1
) (
   input  logic [W-1:0]     din,
   input  logic [CNT_W-1:0] amt,
   input  logic             arith,
   output logic [W-1:0]     dout
);
   localparam int STG   = $clog2(W);
   localparam int MAG_W = CNT_W + 1;

   if (W != (1 << STG)) begin : g_chk_w
      $error("shx_barrel: W must be a power of two");
   end
   if ((1 << (CNT_W - 1)) <= W) begin : g_chk_cnt
      $error("shx_barrel: CNT_W too small to express a saturating count");
   end

   logic             neg;
   logic [MAG_W-1:0] mag;
   logic             ovf;
   logic             fill;

   always_comb begin
      neg  = amt[CNT_W-1];
      mag  = neg ? (~{amt[CNT_W-1], amt} + 1'b1) : {1'b0, amt};
      ovf  = (mag >= MAG_W'(W));
      fill = arith & neg & din[W-1];
   end

   if (LOG_STAGES) begin : g_staged
      logic [W-1:0] stg [STG+1];
      logic [W-1:0] src;
      logic [W-1:0] rev_out;

      always_comb begin
         for (int i = 0; i < W; i++) src[i] = neg ? din[W-1-i] : din[i];
      end
      assign stg[0] = src;

      for (genvar s = 0; s < STG; s++) begin : g_stage
         localparam int SH = 1 << s;
         assign stg[s+1] = mag[s] ? {stg[s][W-1-SH:0], {SH{fill}}} : stg[s];
      end

      always_comb begin
         for (int i = 0; i < W; i++) rev_out[i] = neg ? stg[STG][W-1-i] : stg[STG][i];
      end
      assign dout = ovf ? {W{fill}} : rev_out;
   end else begin : g_operator
      logic [W-1:0] lsh;
      logic [W-1:0] rsh;
      assign lsh = din << mag;
      assign rsh = arith ? W'($signed(din) >>> mag) : (din >> mag);
      assign dout = ovf ? {W{fill}} : (neg ? rsh : lsh);
   end
endmodule

// File: rtl/shx_lead.sv
module shx_lead #(
   parameter int W = 16,
   localparam int LC_W = $clog2(W + 1)
) (
   input  logic [W-1:0]    word,
   input  logic            ref_bit,
   output logic [LC_W-1:0] run_len
);
   logic run;

   always_comb begin
      run_len = '0;
      run     = 1'b1;
      for (int i = W - 1; i >= 0; i--) begin
         if (run && (word[i] == ref_bit)) run_len = run_len + 1'b1;
         else                             run = 1'b0;
      end
   end
endmodule

// File: rtl/shx_unit.sv
module shx_unit
   import shx_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int CNT_W      = 8,
   parameter int EXP_W      = 8,
   parameter bit LOG_STAGES = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [2:0]          op_sel,
   input  logic                hi_half,
   input  logic                merge_en,
   input  logic [CNT_W-1:0]    shift_amt,
   input  logic [DATA_W-1:0]   operand,
   output logic                out_valid,
   output logic [2*DATA_W-1:0] result,
   output logic [EXP_W-1:0]    exponent
);
   localparam int OUT_W = 2 * DATA_W;
   localparam int LC_W  = $clog2(DATA_W + 1);
   localparam logic signed [EXP_W-1:0] EXP_FLOOR_HI = EXP_W'(-(DATA_W - 1));
   localparam logic signed [EXP_W-1:0] EXP_FLOOR    = EXP_W'(-(OUT_W - 1));

   if (DATA_W < 2) begin : g_chk_data
      $error("shx_unit: DATA_W must be at least 2");
   end
   if ((1 << (EXP_W - 1)) < OUT_W) begin : g_chk_exp
      $error("shx_unit: EXP_W cannot hold the lowest exponent");
   end

   shx_op_e op;
   assign op = shx_op_e'(op_sel);

   logic [OUT_W-1:0]               placed;
   logic [CNT_W-1:0]               amt;
   logic                           arith;
   logic [OUT_W-1:0]               shifted;
   logic [LC_W-1:0]                lead_n;
   logic                           lead_ref;
   logic signed [EXP_W-1:0]        exp_q;
   logic signed [EXP_W-1:0]        exp_hi;
   logic signed [EXP_W-1:0]        exp_lo;
   logic                           sign_q;
   logic [OUT_W-1:0]               res_q;
   logic                           vld_q;

   // operand placement into the wide field
   always_comb begin
      if (hi_half)            placed = {operand, {DATA_W{1'b0}}};
      else if (op == OP_ASH)  placed = {{DATA_W{operand[DATA_W-1]}}, operand};
      else                    placed = {{DATA_W{1'b0}}, operand};
   end

   // count and fill selection
   always_comb begin
      unique case (op)
         OP_NORM:   amt = CNT_W'(-exp_q);
         OP_DENORM: amt = CNT_W'(exp_q);
         default:   amt = shift_amt;
      endcase
      arith = (op == OP_ASH) || ((op == OP_DENORM) && hi_half);
   end

   shx_barrel #(.W(OUT_W), .CNT_W(CNT_W), .LOG_STAGES(LOG_STAGES)) u_barrel (
      .din  (placed),
      .amt  (amt),
      .arith(arith),
      .dout (shifted)
   );

   // leading run: own sign for the upper word, stored sign for the lower word
   assign lead_ref = hi_half ? operand[DATA_W-1] : sign_q;

   shx_lead #(.W(DATA_W)) u_lead (
      .word   (operand),
      .ref_bit(lead_ref),
      .run_len(lead_n)
   );

   assign exp_hi = EXP_W'(1) - EXP_W'(lead_n);
   assign exp_lo = EXP_FLOOR_HI - EXP_W'(lead_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q  <= '0;
         exp_q  <= '0;
         sign_q <= 1'b0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            unique case (op)
               OP_LSH, OP_ASH, OP_NORM, OP_DENORM:
                  res_q <= shifted | (merge_en ? res_q : '0);
               OP_EXP: begin
                  if (hi_half) begin
                     exp_q  <= exp_hi;
                     sign_q <= operand[DATA_W-1];
                  end else if (exp_q == EXP_FLOOR_HI) begin
                     exp_q  <= exp_lo;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign result    = res_q;
   assign exponent  = exp_q;
   assign out_valid = vld_q;

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && $stable(exponent)));
   a_r7_exp_range: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(exponent) <= 0) && ($signed(exponent) >= EXP_FLOOR));
   a_r11_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op_sel > 3'd4)) |=> ($stable(result) && $stable(exponent)));
   a_r8_norm_keeps_exp: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op_sel == 3'd2 || op_sel == 3'd3)) |=> $stable(exponent));
   a_r6_exp_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op_sel == 3'd4)) |=> $stable(result));
endmodule

// File: tb/shx_unit_bench.sv
`timescale 1ns/1ps
module shx_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op_sel = 3'd0;
   logic        hi_half = 1'b0;
   logic        merge_en = 1'b0;
   logic [7:0]  shift_amt = 8'd0;
   logic [15:0] operand = 16'd0;
   logic        out_valid;
   logic [31:0] result;
   logic [7:0]  exponent;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   shx_unit u_shx_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .hi_half(hi_half), .merge_en(merge_en), .shift_amt(shift_amt),
      .operand(operand), .out_valid(out_valid), .result(result),
      .exponent(exponent)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_exp(input string tag, input int e);
      chk(tag, {{24{exponent[7]}}, exponent}, 32'(e));
   endtask

   // issue one operand; returns sampled at the negedge after the capturing edge
   task automatic issue(input logic [2:0] op, input logic hi, input logic mrg,
                        input int cnt, input logic [15:0] d);
      @(negedge clk);
      in_valid = 1'b1; op_sel = op; hi_half = hi; merge_en = mrg;
      shift_amt = 8'(cnt); operand = d;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 result in reset", result, 32'h0);
      chk("R1 valid in reset", {31'd0, out_valid}, 32'd0);
      chk_exp("R1 exponent in reset", 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R1 result after release", result, 32'h0);
      chk("R1 valid after release", {31'd0, out_valid}, 32'd0);
   endtask

   task automatic t_logical;
      issue(3'd0, 1'b1, 1'b0, 4, 16'h8001);
      chk("R3 lsh hi left", result, 32'h0010_0000);
      chk("R2 valid after accept", {31'd0, out_valid}, 32'd1);
      @(negedge clk);
      chk("R2 valid drops", {31'd0, out_valid}, 32'd0);
      issue(3'd0, 1'b1, 1'b0, -4, 16'h8001);
      chk("R3 lsh hi right", result, 32'h0800_1000);
      issue(3'd0, 1'b0, 1'b0, 3, 16'h8001);
      chk("R3 lsh lo left", result, 32'h0004_0008);
      issue(3'd0, 1'b0, 1'b0, -1, 16'h8001);
      chk("R3 lsh lo right", result, 32'h0000_4000);
   endtask

   task automatic t_arith;
      issue(3'd1, 1'b0, 1'b0, -4, 16'h8001);
      chk("R4 ash lo sign extend", result, 32'hFFFF_F800);
      issue(3'd1, 1'b1, 1'b0, -4, 16'h8001);
      chk("R4 ash hi right", result, 32'hF800_1000);
      issue(3'd1, 1'b1, 1'b0, 0, 16'h1234);
      chk("R4 ash zero count", result, 32'h1234_0000);
   endtask

   task automatic t_saturate;
      issue(3'd0, 1'b1, 1'b0, 32, 16'hFFFF);
      chk("R5 lsh +32", result, 32'h0);
      issue(3'd1, 1'b0, 1'b0, 31, 16'h0001);
      chk("R5 ash +31", result, 32'h8000_0000);
      issue(3'd0, 1'b1, 1'b0, -32, 16'hFFFF);
      chk("R5 lsh -32", result, 32'h0);
      issue(3'd1, 1'b1, 1'b0, -40, 16'h8000);
      chk("R5 ash -40 negative", result, 32'hFFFF_FFFF);
      issue(3'd1, 1'b1, 1'b0, -128, 16'h7000);
      chk("R5 ash -128 positive", result, 32'h0);
      issue(3'd1, 1'b1, 1'b0, -128, 16'h8000);
      chk("R5 ash -128 negative", result, 32'hFFFF_FFFF);
      issue(3'd0, 1'b0, 1'b0, 127, 16'h0001);
      chk("R5 lsh +127", result, 32'h0);
   endtask

   task automatic t_exponent;
      issue(3'd0, 1'b1, 1'b0, 0, 16'hABCD);
      issue(3'd4, 1'b1, 1'b0, 0, 16'h0100);
      chk_exp("R6 exp 0x0100", -6);
      chk("R6 result untouched", result, 32'hABCD_0000);
      issue(3'd4, 1'b1, 1'b0, 0, 16'h4000);
      chk_exp("R6 exp 0x4000", 0);
      issue(3'd4, 1'b1, 1'b0, 0, 16'hC000);
      chk_exp("R6 exp 0xC000", -1);
      issue(3'd4, 1'b1, 1'b0, 0, 16'h8000);
      chk_exp("R6 exp 0x8000", 0);
      issue(3'd4, 1'b1, 1'b0, 0, 16'hFFFF);
      chk_exp("R6 exp all ones", -15);
      issue(3'd4, 1'b0, 1'b0, 0, 16'hFFF0);
      chk_exp("R7 lo ext after ones", -27);
      issue(3'd4, 1'b1, 1'b0, 0, 16'h0000);
      chk_exp("R6 exp all zeros", -15);
      issue(3'd4, 1'b0, 1'b0, 0, 16'h0000);
      chk_exp("R7 lo ext all zeros", -31);
      issue(3'd4, 1'b1, 1'b0, 0, 16'h0100);
      issue(3'd4, 1'b0, 1'b0, 0, 16'h1234);
      chk_exp("R7 lo keeps non-floor", -6);
      chk("R7 result untouched", result, 32'hABCD_0000);
   endtask

   task automatic t_normalize;
      issue(3'd4, 1'b1, 1'b0, 0, 16'h0100);
      issue(3'd2, 1'b1, 1'b0, 99, 16'h0100);
      chk("R8 norm hi", result, 32'h4000_0000);
      chk_exp("R8 norm keeps exp", -6);
      issue(3'd2, 1'b0, 1'b1, 0, 16'h8001);
      chk("R8 norm lo merged zero ext", result, 32'h4020_0040);
      issue(3'd4, 1'b1, 1'b0, 0, 16'h0000);
      issue(3'd4, 1'b0, 1'b0, 0, 16'h00F0);
      chk_exp("R7 lo ext positive", -23);
      issue(3'd2, 1'b1, 1'b0, 0, 16'h0000);
      issue(3'd2, 1'b0, 1'b1, 0, 16'h00F0);
      chk("R8 two-word positive", result, 32'h7800_0000);
      issue(3'd4, 1'b1, 1'b0, 0, 16'hFFFF);
      issue(3'd4, 1'b0, 1'b0, 0, 16'hFFF0);
      issue(3'd2, 1'b1, 1'b0, 0, 16'hFFFF);
      issue(3'd2, 1'b0, 1'b1, 0, 16'hFFF0);
      chk("R8 two-word negative", result, 32'h8000_0000);
   endtask

   task automatic t_denormalize;
      issue(3'd4, 1'b1, 1'b0, 0, 16'h0100);
      issue(3'd3, 1'b1, 1'b0, 0, 16'h8000);
      chk("R9 denorm hi arith", result, 32'hFE00_0000);
      issue(3'd3, 1'b0, 1'b1, 0, 16'h8000);
      chk("R9 denorm lo logical merged", result, 32'hFE00_0200);
      chk_exp("R9 denorm keeps exp", -6);
   endtask

   task automatic t_merge;
      issue(3'd0, 1'b1, 1'b0, 0, 16'h1200);
      issue(3'd0, 1'b0, 1'b1, 0, 16'h00FF);
      chk("R10 merge or", result, 32'h1200_00FF);
      issue(3'd0, 1'b0, 1'b0, 0, 16'h00FF);
      chk("R10 no merge replaces", result, 32'h0000_00FF);
   endtask

   task automatic t_quiet;
      issue(3'd4, 1'b1, 1'b0, 0, 16'h0100);
      issue(3'd0, 1'b1, 1'b0, 0, 16'h5A5A);
      for (int c = 5; c < 8; c++) begin
         issue(3'(c), 1'b1, 1'b1, 3, 16'hFFFF);
         chk("R11 reserved result", result, 32'h5A5A_0000);
         chk_exp("R11 reserved exponent", -6);
      end
      @(negedge clk);
      op_sel = 3'd4; hi_half = 1'b1; operand = 16'h0000; in_valid = 1'b0;
      @(negedge clk);
      chk("R2 idle keeps result", result, 32'h5A5A_0000);
      chk_exp("R2 idle keeps exponent", -6);
      chk("R2 idle no valid", {31'd0, out_valid}, 32'd0);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #3;
      t_reset();
      t_logical();
      t_arith();
      t_saturate();
      t_exponent();
      t_normalize();
      t_denormalize();
      t_merge();
      t_quiet();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule